// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block owns the refresh side of an asynchronous-strobe DRAM. Out of reset it keeps both strobes idle for a power-up pause. It then runs a fixed burst of CAS-before-RAS refresh cycles on its own, with no bus grant needed, and raises `ready_o` when the burst is done. From then on an interval timer adds one refresh to a saturating backlog at a fixed period. The block asks the access controller for the bus with `req_o` and runs one CAS-before-RAS strobe sequence each time `grant_i` is seen high while it is idle.

A one-cycle pulse on `sleep_i` starts a low-power sequence. The block first runs one ordinary refresh. It then starts a further CAS-before-RAS cycle and keeps the row strobe low, so that the device refreshes itself. A pulse on `wake_i` ends this hold, but only once the row strobe has been low for at least the minimum self-refresh time. The exit uses the longer self-refresh precharge. The backlog is then set to exactly one, so that a refresh is requested at once, and the interval timer starts again from zero. Addresses and data are left to the access controller.

All times are parameters counted in clock cycles. The defaults suit a 100 MHz clock.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset is released, `ras_n_o` and `cas_n_o` stay high for exactly `PWRUP_CYC` clock edges; `cas_n_o` first falls on edge `PWRUP_CYC`.
- R2: After the pause, `INIT_REFS` back-to-back refresh cycles run whatever `grant_i` is; `ready_o` is low until the last of them has completed its precharge, and stays high from then on.
- R3: In every refresh cycle `cas_n_o` goes low exactly `SETUP_CYC` cycles before `ras_n_o` falls, stays low for as long as `ras_n_o` is low, and rises in the same cycle as `ras_n_o`.
- R4: In every refresh cycle other than a self-refresh hold, `ras_n_o` is low for exactly `LOW_CYC` cycles.
- R5: Between two refresh cycles both strobes are high for at least `RP_CYC` cycles.
- R6: Once `ready_o` is high, a refresh is added to the backlog every `INTERVAL_CYC` cycles, the first one `INTERVAL_CYC` cycles after `ready_o` rises. The backlog saturates at `BACKLOG_MAX`, and `req_o` is high exactly while the backlog is nonzero or a sleep request is pending, outside self-refresh.
- R7: Once `ready_o` is high, a refresh cycle starts only in a cycle in which `grant_i` is high while the block is idle. Each completed refresh removes one entry from the backlog.
- R8: A `sleep_i` pulse while ready results in exactly one ordinary refresh cycle. It is followed directly by one held cycle during which `self_o` is high and `req_o` is low.
- R9: During self-refresh `ras_n_o` stays low until `wake_i` has been seen. It stays low for at least `SELF_MIN_CYC` cycles, and for exactly `SELF_MIN_CYC` cycles when the wake pulse comes earlier.
- R10: After self-refresh both strobes stay high for at least `RPS_CYC` cycles. `req_o` is high in the first cycle after `self_o` falls, and the next interval request follows `INTERVAL_CYC` cycles after that exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| grant_i | input | 1 | Access controller hands the DRAM bus to this block |
| sleep_i | input | 1 | Pulse: enter self-refresh |
| wake_i | input | 1 | Pulse: leave self-refresh |
| req_o | output | 1 | Refresh work is waiting and needs the bus |
| ready_o | output | 1 | Initialization finished; normal access allowed |
| self_o | output | 1 | Self-refresh sequence in progress |
| ras_n_o | output | 1 | Row strobe to the DRAM, active low |
| cas_n_o | output | 1 | Column strobe to the DRAM (both byte strobes), active low |

## Verification
The grant line is tried in four ways. With grant held low, the check is that no strobe moves and that the backlog saturates at eight instead of wrapping. A single long grant after that drains the backlog and shows how many entries were kept. A random grant pattern, seen 3 out of 4 cycles, checks that every interval request is served exactly once. A steady grant during the sleep sequences separates the pre-entry refresh from the held cycle. Two sleep runs, one woken early and one woken late, separate the minimum hold from the hold that waits for wake.

// File: rtl/refsch_pkg.sv
package refsch_pkg;

  typedef enum logic [2:0] {
    ST_PWR,
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_PRE
  } st_e;

  typedef enum logic [1:0] {
    K_INIT,
    K_NORM,
    K_PRESELF,
    K_SELF
  } kind_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/refsch_backlog.sv
module refsch_backlog #(
  parameter int INTERVAL_CYC = 1560,
  parameter int BACKLOG_MAX  = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  input  logic done_i,
  output logic nz_o
);
  localparam int TW = $clog2(INTERVAL_CYC + 1);
  localparam int BW = $clog2(BACKLOG_MAX + 1);
  localparam logic [TW-1:0] T_LAST = TW'(INTERVAL_CYC - 1);
  localparam logic [BW-1:0] B_MAX  = BW'(BACKLOG_MAX);

  logic [TW-1:0] tcnt_q;
  logic [BW-1:0] pend_q;
  logic tick, dec;

  assign tick = run_i && (tcnt_q == T_LAST);
  assign dec  = done_i && (pend_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tcnt_q <= '0;
    else if (restart_i) tcnt_q <= '0;
    else if (run_i) tcnt_q <= tick ? '0 : tcnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else if (restart_i) pend_q <= BW'(1);
    else if (tick && !dec && pend_q != B_MAX) pend_q <= pend_q + 1'b1;
    else if (dec && !tick) pend_q <= pend_q - 1'b1;
  end

  assign nz_o = (pend_q != '0);

  assert_backlog_cap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q <= B_MAX);
  assert_saturate_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q == B_MAX && !done_i && !restart_i) |=> (pend_q == B_MAX));
  assert_exit_one_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (pend_q == BW'(1)));

endmodule

// File: rtl/refsch_seq.sv
module refsch_seq
  import refsch_pkg::*;
#(
  parameter int PWRUP_CYC    = 10000,
  parameter int INIT_REFS    = 8,
  parameter int SETUP_CYC    = 1,
  parameter int LOW_CYC      = 6,
  parameter int RP_CYC       = 5,
  parameter int RPS_CYC      = 13,
  parameter int SELF_MIN_CYC = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic grant_i,
  input  logic sleep_i,
  input  logic wake_i,
  input  logic pend_nz_i,
  output logic ready_o,
  output logic self_o,
  output logic sleep_pend_o,
  output logic done_o,
  output logic exit_o,
  output logic ras_n_o,
  output logic cas_n_o
);
  localparam int MAXC = imax(imax(imax(PWRUP_CYC, SETUP_CYC), imax(LOW_CYC, RP_CYC)),
                             imax(RPS_CYC, SELF_MIN_CYC));
  localparam int CW = $clog2(MAXC + 1);
  localparam int IW = $clog2(INIT_REFS + 1);
  localparam logic [CW-1:0] PWR_LAST   = CW'(PWRUP_CYC - 1);
  localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] LOW_LAST   = CW'(LOW_CYC - 1);
  localparam logic [CW-1:0] RP_LAST    = CW'(RP_CYC - 1);
  localparam logic [CW-1:0] RPS_LAST   = CW'(RPS_CYC - 1);
  localparam logic [CW-1:0] SELF_LAST  = CW'(SELF_MIN_CYC - 1);
  localparam logic [IW-1:0] INIT_LAST  = IW'(INIT_REFS - 1);

  st_e   st_q, st_d;
  kind_e kind_q, kind_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] init_q, init_d;
  logic ready_q, ready_d, sleep_q, wake_q, last;

  always_comb begin
    st_d    = st_q;
    kind_d  = kind_q;
    cnt_d   = cnt_q;
    init_d  = init_q;
    ready_d = ready_q;
    last    = 1'b0;
    unique case (st_q)
      ST_PWR: begin
        if (cnt_q == PWR_LAST) begin
          st_d = ST_SETUP; cnt_d = '0; kind_d = K_INIT;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_IDLE: begin
        if (sleep_q && grant_i) begin
          st_d = ST_SETUP; cnt_d = '0; kind_d = K_PRESELF;
        end else if (pend_nz_i && grant_i) begin
          st_d = ST_SETUP; cnt_d = '0; kind_d = K_NORM;
        end
      end
      ST_SETUP: begin
        if (cnt_q == SETUP_LAST) begin
          st_d = ST_STROBE; cnt_d = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_STROBE: begin
        if (kind_q == K_SELF) begin
          // hold at least the self-refresh minimum, then wait for wake
          if (cnt_q == SELF_LAST) begin
            if (wake_q) begin st_d = ST_PRE; cnt_d = '0; end
          end else cnt_d = cnt_q + 1'b1;
        end else if (cnt_q == LOW_LAST) begin
          st_d = ST_PRE; cnt_d = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_PRE: begin
        last = (cnt_q == ((kind_q == K_SELF) ? RPS_LAST : RP_LAST));
        if (!last) cnt_d = cnt_q + 1'b1;
        else begin
          cnt_d = '0;
          unique case (kind_q)
            K_INIT: begin
              init_d = init_q + 1'b1;
              if (init_q == INIT_LAST) begin
                st_d = ST_IDLE; ready_d = 1'b1; kind_d = K_NORM;
              end else st_d = ST_SETUP;
            end
            K_PRESELF: begin st_d = ST_SETUP; kind_d = K_SELF; end
            default:   begin st_d = ST_IDLE;  kind_d = K_NORM; end
          endcase
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_PWR;
      kind_q  <= K_INIT;
      cnt_q   <= '0;
      init_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      kind_q  <= kind_d;
      cnt_q   <= cnt_d;
      init_q  <= init_d;
      ready_q <= ready_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sleep_q <= 1'b0;
    else if (st_q == ST_PRE && last && kind_q == K_PRESELF) sleep_q <= 1'b0;
    else if (sleep_i && ready_q && kind_q != K_PRESELF && kind_q != K_SELF) sleep_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wake_q <= 1'b0;
    else if (exit_o) wake_q <= 1'b0;
    else if (wake_i && st_q == ST_STROBE && kind_q == K_SELF) wake_q <= 1'b1;
  end

  assign ready_o      = ready_q;
  assign self_o       = (kind_q == K_SELF);
  assign sleep_pend_o = sleep_q;
  assign done_o       = (st_q == ST_PRE) && last && (kind_q == K_NORM || kind_q == K_PRESELF);
  assign exit_o       = (st_q == ST_PRE) && last && (kind_q == K_SELF);
  assign ras_n_o      = (st_q != ST_STROBE);
  assign cas_n_o      = !(st_q == ST_SETUP || st_q == ST_STROBE);

  // low-time counter for checking only
  logic [CW-1:0] chk_low_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chk_low_q <= '0;
    else if (ras_n_o) chk_low_q <= '0;
    else if (chk_low_q != '1) chk_low_q <= chk_low_q + 1'b1;
  end

  assert_cas_covers_ras_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n_o |-> !cas_n_o);
  assert_cas_leads_ras_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> $past(!cas_n_o));
  assert_ready_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
  assert_grant_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !grant_i) |=> (st_q == ST_IDLE));
  assert_norm_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ras_n_o) && kind_q != K_SELF) |-> (chk_low_q == CW'(LOW_CYC)));
  assert_self_min_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ras_n_o) && kind_q == K_SELF) |-> (chk_low_q >= CW'(SELF_MIN_CYC)));
  assert_self_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_STROBE && kind_q == K_SELF && !wake_q) |=> !ras_n_o);

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int PWRUP_CYC    = 10000,
  parameter int INIT_REFS    = 8,
  parameter int INTERVAL_CYC = 1560,
  parameter int BACKLOG_MAX  = 8,
  parameter int SETUP_CYC    = 1,
  parameter int LOW_CYC      = 6,
  parameter int RP_CYC       = 5,
  parameter int RPS_CYC      = 13,
  parameter int SELF_MIN_CYC = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic grant_i,
  input  logic sleep_i,
  input  logic wake_i,
  output logic req_o,
  output logic ready_o,
  output logic self_o,
  output logic ras_n_o,
  output logic cas_n_o
);
  logic pend_nz, sleep_pend, done, exit_s;

  refsch_seq #(
    .PWRUP_CYC(PWRUP_CYC), .INIT_REFS(INIT_REFS), .SETUP_CYC(SETUP_CYC),
    .LOW_CYC(LOW_CYC), .RP_CYC(RP_CYC), .RPS_CYC(RPS_CYC), .SELF_MIN_CYC(SELF_MIN_CYC)
  ) u_seq (
    .clk_i, .rst_ni, .grant_i, .sleep_i, .wake_i,
    .pend_nz_i(pend_nz), .ready_o, .self_o, .sleep_pend_o(sleep_pend),
    .done_o(done), .exit_o(exit_s), .ras_n_o, .cas_n_o
  );

  refsch_backlog #(
    .INTERVAL_CYC(INTERVAL_CYC), .BACKLOG_MAX(BACKLOG_MAX)
  ) u_backlog (
    .clk_i, .rst_ni,
    .run_i(ready_o && !self_o), .restart_i(exit_s), .done_i(done), .nz_o(pend_nz)
  );

  assign req_o = ready_o && !self_o && (pend_nz || sleep_pend);

  assert_req_after_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> ready_o);
  assert_quiet_in_self_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    self_o |-> !req_o);

endmodule

// File: tb/dram_refresh_sched_test.sv
module dram_refresh_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int PWRUP = 50, INIT = 8, INTV = 200, BMAX = 8;
  localparam int SETUP = 2, LOW = 4, RP = 3, RPS = 7, SELF_MIN = 30;

  logic clk = 0, rst_ni = 0, grant = 0, sleep = 0, wake = 0;
  logic req_o, ready_o, self_o, ras_n_o, cas_n_o;

  dram_refresh_sched #(
    .PWRUP_CYC(PWRUP), .INIT_REFS(INIT), .INTERVAL_CYC(INTV), .BACKLOG_MAX(BMAX),
    .SETUP_CYC(SETUP), .LOW_CYC(LOW), .RP_CYC(RP), .RPS_CYC(RPS), .SELF_MIN_CYC(SELF_MIN)
  ) uut (
    .clk_i(clk), .rst_ni, .grant_i(grant), .sleep_i(sleep), .wake_i(wake),
    .req_o, .ready_o, .self_o, .ras_n_o, .cas_n_o
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) if (rst_ni) cyc <= cyc + 1;

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  int t0;
  function automatic int exp_ticks(input int c);
    return (c - t0) / INTV + 1;
  endfunction
  function automatic int exp_backlog(input int n);
    return (n > BMAX) ? BMAX : n;
  endfunction

  // strobe monitor
  bit prev_ras = 1, prev_cas = 1, prev_grant = 0, low_self = 0, rps_due = 0;
  bit first_cas_seen = 0, ready_seen = 0;
  int first_cas_cyc = 0, ready_cyc = 0, low_run = 0, last_low_len = 0;
  int setup_run = 0, both_high_run = 0, falls_norm = 0, falls_self = 0;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (prev_cas && !cas_n_o) begin
        if (!first_cas_seen) begin
          first_cas_seen = 1; first_cas_cyc = cyc;
        end else if (rps_due)
          chk(both_high_run >= RPS, "R10 exit precharge", both_high_run, RPS);
        else
          chk(both_high_run >= RP, "R5 precharge", both_high_run, RP);
        if (ready_o && !self_o) chk(prev_grant, "R7 start needs grant", prev_grant, 1);
        rps_due = 0;
      end
      if (prev_ras && !ras_n_o) begin
        chk(setup_run == SETUP, "R3 cas lead", setup_run, SETUP);
        if (self_o) falls_self++; else falls_norm++;
        low_run = 1; low_self = self_o;
      end else if (!ras_n_o) begin
        low_run++; low_self |= self_o;
      end
      if (!ras_n_o && cas_n_o) chk(0, "R3 cas high under ras", 1, 0);
      if (!prev_ras && ras_n_o) begin
        chk(cas_n_o == 1, "R3 joint rise", cas_n_o, 1);
        last_low_len = low_run;
        if (low_self) chk(low_run >= SELF_MIN, "R9 self hold", low_run, SELF_MIN);
        else chk(low_run == LOW, "R4 low width", low_run, LOW);
        rps_due = low_self;
      end
      setup_run     = (!cas_n_o && ras_n_o) ? setup_run + 1 : 0;
      both_high_run = (cas_n_o && ras_n_o) ? both_high_run + 1 : 0;
      if (ready_o && !ready_seen) begin ready_seen = 1; ready_cyc = cyc; end
      prev_ras = ras_n_o; prev_cas = cas_n_o; prev_grant = grant;
    end
  end

  task automatic at_neg; @(negedge clk); #1; endtask
  task automatic step; @(posedge clk); #2; endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    int base, n_grant, lost, e_cyc, base_s;
    void'($urandom(32'd20240611));
    #3;
    chk(ras_n_o && cas_n_o, "R1 reset strobes", {ras_n_o, cas_n_o}, 3);
    chk(!req_o && !ready_o && !self_o, "R2 reset ready/req", {req_o, ready_o, self_o}, 0);
    repeat (3) @(posedge clk);
    #2 rst_ni = 1;

    while (!first_cas_seen) at_neg();
    chk(first_cas_cyc == PWRUP, "R1 power-up pause", first_cas_cyc, PWRUP);

    while (!ready_seen) at_neg();
    chk(falls_norm == INIT, "R2 init burst count", falls_norm, INIT);

    while (!req_o) at_neg();
    t0 = cyc;
    chk(t0 - ready_cyc == INTV, "R6 first interval", t0 - ready_cyc, INTV);

    // withhold grant: backlog must saturate
    while (cyc < t0 + 10 * INTV + 5) at_neg();
    chk(falls_norm == INIT, "R7 no strobe without grant", falls_norm, INIT);
    chk(req_o == 1, "R6 request held", req_o, 1);
    step();
    n_grant = exp_ticks(cyc);
    base = falls_norm;
    grant = 1;
    at_neg();
    while (req_o) at_neg();
    chk(falls_norm - base == exp_backlog(n_grant), "R6 saturating backlog",
        falls_norm - base, exp_backlog(n_grant));
    lost = n_grant - exp_backlog(n_grant);

    // random grant pattern
    for (int i = 0; i < 3000; i++) begin
      step();
      grant = ($urandom % 4) != 0;
    end
    step();
    grant = 1;
    at_neg();
    while (req_o) at_neg();
    chk(falls_norm - INIT == exp_ticks(cyc) - lost, "R7 every interval served once",
        falls_norm - INIT, exp_ticks(cyc) - lost);

    // self-refresh, early wake
    step();
    base = falls_norm; base_s = falls_self;
    sleep = 1;
    step();
    sleep = 0;
    at_neg();
    while (!(self_o && !ras_n_o)) at_neg();
    chk(falls_norm - base == 1, "R8 pre-entry refresh", falls_norm - base, 1);
    chk(falls_self - base_s == 1, "R8 held entry", falls_self - base_s, 1);
    chk(req_o == 0, "R8 no request in self", req_o, 0);
    repeat (3) step();
    wake = 1;
    step();
    wake = 0;
    at_neg();
    while (!ras_n_o) at_neg();
    chk(last_low_len == SELF_MIN, "R9 early wake exact", last_low_len, SELF_MIN);
    while (self_o) at_neg();
    e_cyc = cyc;
    chk(req_o == 1, "R10 post-exit request", req_o, 1);
    base = falls_norm;
    while (req_o) at_neg();
    chk(falls_norm - base == 1, "R10 post-exit refresh", falls_norm - base, 1);
    while (!req_o) at_neg();
    chk(cyc - e_cyc == INTV, "R10 timer restart", cyc - e_cyc, INTV);
    while (req_o) at_neg();

    // self-refresh, late wake
    step();
    sleep = 1;
    step();
    sleep = 0;
    at_neg();
    while (!(self_o && !ras_n_o)) at_neg();
    repeat (SELF_MIN + 25) step();
    chk(ras_n_o == 0, "R9 waits for wake", ras_n_o, 0);
    wake = 1;
    step();
    wake = 0;
    at_neg();
    while (!ras_n_o) at_neg();
    chk(last_low_len >= SELF_MIN + 25, "R9 late wake length", last_low_len, SELF_MIN + 25);
    while (self_o) at_neg();
    while (req_o) at_neg();
    repeat (5) at_neg();
    finish_run();
  end
endmodule